// File: doc/BRIEF.md
# GPIO Port with Read-Modify-Write Bit Operations

This block is a general-purpose I/O port. Each pin has a direction bit and a data-latch bit. An output pin drives its latch bit onto the pad, and an input pin leaves its pad undriven. A small register bus lets software program the direction and the latch, read back the port value and the raw latch, and ask for a single bit of the port to be set or cleared.

Reading the port mixes two sources bit by bit. For an input pin the read takes the synchronized pad level. For an output pin it takes the latch bit. A bit-set or bit-clear request runs as a read-modify-write sequence. The sequencer samples that mixed port value, forces the chosen bit, and then writes the entire byte back into the latch. As a result, the latch bits of input pins are overwritten with whatever levels those pads had when they were sampled.

Here is a worked example. With direction 0x3F, latch 0x80, pin 7 low and pin 6 high, the port reads 0x40. Setting bit 0 then leaves 0x41 in the latch, so pin 0 drives high. Latch bit 7, which software had written to 1, is now 0.

Top module: `gpio_rmw_port`

## Requirements
- R1: After reset, the direction register and the data latch are both 0x00, every output enable is low, and busy reads 0.
- R2: Each pad output enable equals its direction bit, where 1 means output and 0 means input. Each pad output value equals its latch bit.
- R3: A read at address 1 returns the synchronized pad level for every bit whose direction is 0, and the latch bit for every bit whose direction is 1.
- R4: A bus write at address 1 loads all bits of the latch from wdata and does not sample the pads. A bus write at address 0 loads the direction register. A read at address 2 returns the raw latch, and a read at address 0 returns the direction register.
- R5: A write at address 2 requests a bit-set, with the bit index taken from wdata[2:0]. Two cycles after the request is accepted, the latch holds the port value sampled one cycle after acceptance, with the indexed bit forced to 1. This covers the latch bits of input pins as well.
- R6: A write at address 3 requests a bit-clear. It follows the same timing as R5, but the indexed bit is forced to 0.
- R7: Busy (bit 0 of a read at address 3) is 1 for exactly two cycles after a bit request is accepted. While busy is 1, every bus write is ignored, including further bit requests.
- R8: A change on a pad becomes visible in the port read value, and in the bit-operation sample, after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data or bit index |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| pad_i | input | 8 | Pad input levels |
| pad_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |

## Verification
The bench builds the block with its default parameters: an 8-bit port, a 3-bit index, and a two-stage synchronizer. With these values every bit index, including 0 and 7, is reachable from random and directed stimulus. The short synchronizer keeps pad-to-read latency at two edges, so the bench can hit both the stale and the fresh pad value exactly. Random direction, latch and pad patterns exercise the pad/latch mix on every pin in both polarities. The worked 0x3F/0x80 case and back-to-back requests made while busy are run as directed cases.

// File: rtl/gpio_rmw_pkg.sv
package gpio_rmw_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CAP  = 2'd1,
    SEQ_WB   = 2'd2
  } seq_state_e;

  localparam logic [1:0] ADDR_DIR   = 2'd0;
  localparam logic [1:0] ADDR_PORT  = 2'd1;
  localparam logic [1:0] ADDR_SET   = 2'd2;
  localparam logic [1:0] ADDR_CLR   = 2'd3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_rmw_seq.sv
module gpio_rmw_seq
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             op_set_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WIDTH-1:0] port_val_i,
  output logic             busy_o,
  output logic             wb_valid_o,
  output logic [WIDTH-1:0] wb_data_o
);
  seq_state_e       state_q;
  logic             op_set_q;
  logic [IDX_W-1:0] idx_q;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] modified;

  always_comb begin
    modified        = port_val_i;
    modified[idx_q] = op_set_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      op_set_q <= 1'b0;
      idx_q    <= '0;
      data_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          op_set_q <= op_set_i;
          idx_q    <= idx_i;
          state_q  <= SEQ_CAP;
        end
        SEQ_CAP: begin
          data_q  <= modified;
          state_q <= SEQ_WB;
        end
        SEQ_WB:  state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != SEQ_IDLE);
  assign wb_valid_o = (state_q == SEQ_WB);
  assign wb_data_o  = data_q;

  // R7
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R7
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> (busy_o ##1 !busy_o));
  // R5 R6
  wb_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (wb_data_o[idx_q] == op_set_q));
  // R7
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(idx_q) && $stable(op_set_q)));
endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  logic [WIDTH-1:0] dir_q, latch_q, pad_sync, port_val, wb_data;
  logic             busy, wb_valid, bus_wr, start;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pad_sync)
  );

  // per-bit mix: pad for inputs, latch for outputs
  assign port_val = (pad_sync & ~dir_q) | (latch_q & dir_q);

  assign bus_wr = req_i && we_i && !busy;
  assign start  = bus_wr && addr_i[1];

  gpio_rmw_seq #(.WIDTH(WIDTH)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .op_set_i  (addr_i == ADDR_SET),
    .idx_i     (wdata_i[IDX_W-1:0]),
    .port_val_i(port_val),
    .busy_o    (busy),
    .wb_valid_o(wb_valid),
    .wb_data_o (wb_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      latch_q <= '0;
    end else begin
      if (bus_wr && addr_i == ADDR_DIR) dir_q <= wdata_i;
      if (wb_valid)                            latch_q <= wb_data;
      else if (bus_wr && addr_i == ADDR_PORT)  latch_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_DIR:  rdata_o = dir_q;
      ADDR_PORT: rdata_o = port_val;
      ADDR_SET:  rdata_o = latch_q;
      default:   rdata_o = {{(WIDTH-1){1'b0}}, busy};
    endcase
  end

  assign pad_o    = latch_q;
  assign pad_oe_o = dir_q;

  // R5 R6
  latch_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid |=> (latch_q == $past(wb_data)));
  // R7
  ignore_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(dir_q));
  // R7
  ignore_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !wb_valid) |=> $stable(latch_q));
endmodule

// File: tb/gpio_rmw_port_bench.sv
module gpio_rmw_port_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [W-1:0] wdata = '0, rdata, pad = '0, pad_out, pad_oe;

  int checks = 0, fails = 0;
  logic [W-1:0] dir_m = '0, latch_m = '0;

  always #2.5 clk = ~clk;

  gpio_rmw_port u_gpio_rmw_port (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad), .pad_o(pad_out), .pad_oe_o(pad_oe)
  );

  function automatic logic [W-1:0] port_fn(logic [W-1:0] d, logic [W-1:0] l, logic [W-1:0] p);
    for (int i = 0; i < W; i++) port_fn[i] = d[i] ? l[i] : p[i];
  endfunction

  function automatic logic [W-1:0] rmw_fn(logic [W-1:0] v, int idx, logic s);
    rmw_fn = v;
    rmw_fn[idx] = s;
  endfunction

  task automatic check(string req_tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [W-1:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bit_op(logic set, int idx, string tag);
    logic [W-1:0] v, exp;
    exp = rmw_fn(port_fn(dir_m, latch_m, pad), idx, set);
    bus_wr(set ? 2'd2 : 2'd3, W'(idx));
    bus_rd(2'd3, v);
    check({tag, " R7 busy"}, v, 8'h01);
    idle(2);
    bus_rd(2'd3, v);
    check({tag, " R7 busy done"}, v, 8'h00);
    latch_m = exp;
    bus_rd(2'd2, v);
    check(tag, v, exp);
    check({tag, " R2 pad_o"}, pad_out, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd1234));
    idle(3);
    // R1 reset state
    bus_rd(2'd0, v); check("R1 dir", v, 8'h00);
    bus_rd(2'd2, v); check("R1 latch", v, 8'h00);
    check("R1 oe", pad_oe, 8'h00);
    bus_rd(2'd3, v); check("R1 busy", v, 8'h00);
    rst_n = 1'b1;
    idle(2);

    // R8 synchronizer latency, all inputs
    pad = 8'hA5;
    @(posedge clk); #1; bus_rd(2'd1, v); check("R8 one edge", v, 8'h00);
    @(posedge clk); #1; bus_rd(2'd1, v); check("R8 two edges", v, 8'hA5);

    // worked case: dir 0x3F, latch 0x80, pin7 low, pin6 high
    bus_wr(2'd0, 8'h3F); dir_m = 8'h3F;
    bus_wr(2'd1, 8'h80); latch_m = 8'h80;
    pad = 8'h40; idle(3);
    bus_rd(2'd1, v); check("R3 worked read", v, 8'h40);
    check("R2 oe", pad_oe, 8'h3F);
    bit_op(1'b1, 0, "R5 worked");
    check("R5 worked value", latch_m, 8'h41);

    // R4 plain write does not sample pads
    bus_wr(2'd1, 8'hC3); latch_m = 8'hC3;
    bus_rd(2'd2, v); check("R4 latch write", v, 8'hC3);
    bus_rd(2'd0, v); check("R4 dir read", v, 8'h3F);

    // R6 clear, index 7 (input pin, pad low -> bit 7 stays 0 after RMW)
    bit_op(1'b0, 7, "R6 clr idx7");

    // R7 writes ignored while busy
    bus_wr(2'd0, 8'hFF); dir_m = 8'hFF;
    bus_wr(2'd1, 8'h0F); latch_m = 8'h0F;
    bus_wr(2'd2, 8'd7);
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd0, v); check("R7 dir write ignored", v, 8'hFF);
    idle(1);
    bus_rd(2'd2, v); check("R7 set applied", v, 8'h8F);
    latch_m = 8'h8F;
    bus_wr(2'd3, 8'd0);
    bus_wr(2'd2, 8'd4);
    idle(1);
    bus_rd(2'd2, v); check("R7 second req ignored", v, 8'h8E);
    latch_m = 8'h8E;

    // random patterns
    for (int it = 0; it < 60; it++) begin
      logic [W-1:0] d, l;
      d = W'($urandom); l = W'($urandom);
      bus_wr(2'd0, d); dir_m = d;
      bus_wr(2'd1, l); latch_m = l;
      pad = W'($urandom);
      idle(3);
      bus_rd(2'd1, v); check("R3 random read", v, port_fn(dir_m, latch_m, pad));
      check("R2 random oe", pad_oe, dir_m);
      if ($urandom % 2) bit_op(1'b1, int'($urandom % W), "R5 random set");
      else              bit_op(1'b0, int'($urandom % W), "R6 random clr");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule